// File: doc/BRIEF.md
# Self-Clearing Falling-Edge Word Memory

This block is a word-wide memory for a controller that runs on the rising clock edge and never touches the storage array itself. To ask for an access, the controller drives a byte address, and for a store also a data word and a high write-select. It then inverts a single request flag. A flag that has not changed since the last access requests nothing.

The block works on the falling edge of the same clock. On each falling edge it compares the controller's flag with an acknowledge flag of its own. If the two differ, it performs exactly one whole-word load or store and then copies the controller's flag into its acknowledge register. This makes it idle again before the next rising edge, and the controller needs no state to turn it off.

Because the work happens half a cycle after the request, a store is finished within one controller cycle. A load result is ready for the controller to consume at its second rising edge. All reads and writes of the array sit in one procedural block, so the array maps onto a RAM rather than onto discrete registers.

Top module: `tgl_ram_driver`

## Requirements
- R1: While `rst` is high at a falling edge, the acknowledge flag clears to 0 and `rd_data` clears to 0. With `req_flip` held at 0 through reset, no access is pending after reset.
- R2: An access is pending exactly when `req_flip` differs from the internal acknowledge flag. Inverting `req_flip` in either direction, 0 to 1 or 1 to 0, starts exactly one access.
- R3: At the falling edge that services an access, the acknowledge flag takes the value of `req_flip`, so the block is idle at every rising edge.
- R4: With `wr_en` = 1, a pending access writes `wr_data` into the addressed word at the next falling edge. A load issued in the very next cycle returns the new value.
- R5: With `wr_en` = 0, a pending access copies the addressed word into `rd_data` at the next falling edge. The value is therefore settled before the first rising edge after the request, and the controller uses it at the second rising edge.
- R6: `rd_data` keeps the value of the most recent completed load, and stores and idle cycles leave it unchanged.
- R7: The word index is bits [IDX_W+1:2] of `byte_addr`, where IDX_W = log2(DEPTH_WORDS). Byte-address bits 1:0 and all bits above the index field are ignored.
- R8: Requests issued in consecutive cycles, with `req_flip` inverted every cycle, are each serviced exactly once and in order.
- R9: While `req_flip` is held constant, changes on `wr_en`, `byte_addr` or `wr_data` neither modify the memory nor change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The controller uses the rising edge and the memory uses the falling edge. |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge. |
| req_flip | input | 1 | Request flag. Inverting it asks for one access. |
| wr_en | input | 1 | 1 selects a store and 0 selects a load. |
| byte_addr | input | 32 | Byte address of the word to access. |
| wr_data | input | 32 | Word to store. |
| rd_data | output | 32 | Word from the last load. |

## Verification
The assertions check on every cycle that the acknowledge flag matches the request flag at each rising edge (R3). They also check that the acknowledge flag flips exactly when an access is pending and holds otherwise (R2), and that `rd_data` moves only on a load (R6). Whether the correct word was written or returned, how addresses are decoded, and whether back-to-back and held-flag sequences behave correctly can only be shown by the bench's scenarios. The bench compares every load against a reference array and checks `rd_data` once every cycle.

// File: rtl/tgl_ram_pkg.sv
`timescale 1ns/1ps
package tgl_ram_pkg;

    localparam int WORD_W = 32;
    localparam int BADDR_W = 32;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BADDR_W-1:0] baddr_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2
    } op_kind_e;

    // Word number of a byte address: the byte-lane bits are dropped.
    function automatic baddr_t word_of(input baddr_t a);
        return a >> 2;
    endfunction

    // The request is live while the two flags disagree.
    function automatic logic flags_differ(input logic req, input logic ack);
        return req ^ ack;
    endfunction

endpackage

// File: rtl/tgl_req_decode.sv
`timescale 1ns/1ps
module tgl_req_decode
    import tgl_ram_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             req_flip,
    input  logic             ack_flag,
    input  logic             wr_en,
    input  baddr_t           byte_addr,
    output op_kind_e         op,
    output logic [IDX_W-1:0] idx
);

    logic pending;

    always_comb begin
        pending = flags_differ(req_flip, ack_flag);
        idx     = IDX_W'(word_of(byte_addr));
        if (!pending)
            op = OP_IDLE;
        else if (wr_en)
            op = OP_STORE;
        else
            op = OP_LOAD;
    end

endmodule

// File: rtl/tgl_ack_reg.sv
`timescale 1ns/1ps
module tgl_ack_reg (
    input  logic clk,
    input  logic rst,
    input  logic req_flip,
    output logic ack_flag
);

    // After servicing, the acknowledge flag takes the request value so that
    // the two flags agree and the memory is idle again.
    always_ff @(negedge clk) begin
        if (rst)
            ack_flag <= 1'b0;
        else
            ack_flag <= req_flip;
    end

    AST_ACK_FLIPS_ON_REQ: assert property (@(negedge clk) disable iff (rst)
        (req_flip != ack_flag) |=> (ack_flag != $past(ack_flag))); // R2
    AST_ACK_HOLDS_IDLE: assert property (@(negedge clk) disable iff (rst)
        (req_flip == ack_flag) |=> $stable(ack_flag)); // R2

endmodule

// File: rtl/tgl_ram_array.sv
`timescale 1ns/1ps
module tgl_ram_array
    import tgl_ram_pkg::*;
#(
    parameter int DEPTH_WORDS = 256,
    parameter int IDX_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  op_kind_e         op,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);

    word_t mem [DEPTH_WORDS];

    // The only process that reads or writes the array.
    always_ff @(negedge clk) begin
        if (!rst && op == OP_STORE)
            mem[idx] <= wdata;
        if (rst)
            rdata <= '0;
        else if (op == OP_LOAD)
            rdata <= mem[idx];
    end

    AST_RDATA_ONLY_ON_LOAD: assert property (@(negedge clk) disable iff (rst)
        (op != OP_LOAD) |=> $stable(rdata)); // R6

endmodule

// File: rtl/tgl_ram_driver.sv
`timescale 1ns/1ps
module tgl_ram_driver
    import tgl_ram_pkg::*;
#(
    parameter int DEPTH_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_flip,
    input  logic        wr_en,
    input  logic [31:0] byte_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);

    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

    logic             ack_flag;
    op_kind_e         op;
    logic [IDX_W-1:0] idx;

    tgl_req_decode #(.IDX_W(IDX_W)) decode_i (
        .req_flip  (req_flip),
        .ack_flag  (ack_flag),
        .wr_en     (wr_en),
        .byte_addr (byte_addr),
        .op        (op),
        .idx       (idx)
    );

    tgl_ack_reg ack_i (
        .clk      (clk),
        .rst      (rst),
        .req_flip (req_flip),
        .ack_flag (ack_flag)
    );

    tgl_ram_array #(.DEPTH_WORDS(DEPTH_WORDS), .IDX_W(IDX_W)) array_i (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .idx   (idx),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    // The controller samples on the rising edge. By then any access has been
    // serviced and the flags agree.
    AST_IDLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        (ack_flag == req_flip)); // R3

    initial begin
        AST_DEPTH_POW2: assert ((DEPTH_WORDS & (DEPTH_WORDS - 1)) == 0); // R7
    end

endmodule

// File: tb/tgl_ram_driver_tb.sv
`timescale 1ns/1ps
module tgl_ram_driver_tb_top;

    localparam int DEPTH = 256;
    localparam int IW    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_flip = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] byte_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int unsigned checks = 0;
    int unsigned failures = 0;
    logic [31:0] ref_mem [DEPTH];
    logic [31:0] ref_rd = '0;
    string       pend_tag = "R1";

    always #2 clk = ~clk;

    tgl_ram_driver #(.DEPTH_WORDS(DEPTH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_flip  (req_flip),
        .wr_en     (wr_en),
        .byte_addr (byte_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data)
    );

    function automatic int tb_idx(input logic [31:0] a);
        return int'(a[IW+1:2]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One controller cycle: check the previous outcome, then drive the next request.
    task automatic step(input bit flip, input bit we, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
        @(posedge clk);
        #1;
        check(pend_tag, rd_data, ref_rd);
        wr_en = we;
        byte_addr = a;
        wr_data = d;
        if (flip) begin
            req_flip = ~req_flip;
            if (we) ref_mem[tb_idx(a)] = d;
            else    ref_rd = ref_mem[tb_idx(a)];
        end
        pend_tag = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd9137);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 rd_data after reset", rd_data, 32'h0);
        // R1: an idle cycle after reset leaves rd_data at zero.
        step(1'b0, 1'b1, 32'h10, 32'hDEAD_BEEF, "R1 R9 idle after reset");

        // R4 R8: fill every word with back-to-back stores.
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b1, 32'(i) << 2, $urandom(), "R4 R8 fill");

        // R4: a store followed at once by a load of the same word.
        step(1'b1, 1'b1, 32'h14, 32'hA5A5_0001, "R4 store");
        step(1'b1, 1'b0, 32'h14, 32'h0, "R4 R5 load after store");
        // R7: unaligned lanes and high address bits are ignored.
        step(1'b1, 1'b1, 32'hFFFF_F017, 32'h1234_5678, "R7 store high+unaligned");
        step(1'b1, 1'b0, 32'h0000_0014, 32'h0, "R7 load aliased word");
        step(1'b1, 1'b0, 32'h8000_0416, 32'h0, "R7 load other alias");
        // R6: a store does not disturb rd_data.
        step(1'b1, 1'b1, 32'h20, 32'h0BAD_F00D, "R6 store keeps rd_data");
        step(1'b0, 1'b0, 32'h20, 32'h0, "R6 idle keeps rd_data");

        // R9 R3: held flag with changing inputs performs nothing.
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'(i % 2), 32'(i) << 2, $urandom(), "R9 R3 held flag");
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'b0, 32'(i) << 2, 32'h0, "R9 reload untouched");

        // R5 R8: consecutive loads of distinct words.
        for (int i = 0; i < 24; i++)
            step(1'b1, 1'b0, 32'((i * 7) % DEPTH) << 2, 32'h0, "R5 R8 load burst");

        // R2 R8: random mix of stores, loads and idle cycles.
        for (int i = 0; i < 4000; i++) begin
            bit flip;
            bit we;
            logic [31:0] a;
            flip = ($urandom() % 4) != 0;
            we = $urandom() % 2;
            a = (32'($urandom() % 16) << 2) | 32'($urandom() % 4);
            if ($urandom() % 4 == 0) a = $urandom();
            step(flip, we, a, $urandom(), "R2 R8 random");
        end

        step(1'b0, 1'b0, 32'h0, 32'h0, "R6 final");
        step(1'b0, 1'b0, 32'h0, 32'h0, "R6 final");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule